// File: doc/BRIEF.md
# Six-Source Maskable Interrupt Controller

This block gathers six interrupt requests and gives the processor one request at a time, together with its vector address. There are two external pins, three timer sources and one serial source. Each source has its own enable bit. A master enable bit gates all six sources at once. When several enabled sources are pending together, a fixed polling order picks the one that is presented.

Each external pin can run in one of two modes. In edge mode, a falling edge is captured in a latch. In level mode, the request follows the pin while it is held low. Timers 0 and 1 report a one-cycle overflow pulse, which the block keeps in a flag. The external latches and these two timer flags are cleared by the block when the processor acknowledges their vector. The serial request and the timer-2 request are levels that software owns, and the block never clears them. The timer-2 request is the OR of two separate flags.

After an acknowledge, the block holds back every new request until it sees a return-from-interrupt pulse.

Top module: `irq_ctl`

## Requirements
- R1: After reset, the enable register reads 0, `irq_req` is low and every bit of `src_pend` is 0.
- R2: A write to the enable register stores bits 7 and 5..0. Bit 6 is reserved: it always reads 0 and writes to it have no effect.
- R3: While enable bit 7 (the master enable) is 0, `irq_req` stays low whatever requests are pending.
- R4: Enable bits 0..5 gate sources 0..5. A pending source whose bit is 0 is never presented.
- R5: Source indices are fixed: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2. Among enabled pending sources, the lowest index is presented on `irq_idx`.
- R6: `irq_vec` equals 8'h03 + 8 × `irq_idx`. This gives 0x03, 0x0B, 0x13, 0x1B, 0x23 and 0x2B.
- R7: In edge mode (`extN_edge`=1), a high-to-low transition of `extN_n` sets a latch that stays set after the pin returns high. Acknowledging that source clears the latch. In level mode, the request is simply the inverted pin.
- R8: A one-cycle `tmrN_ovf` pulse for timer 0 or timer 1 sets a flag. The flag stays set until that source is acknowledged.
- R9: The timer-2 request is `t2_ovf` OR `t2_ext`, and the serial request is `ser_req`. Acknowledging either of these sources leaves its request pending.
- R10: An `irq_ack` while `irq_req` is high puts the block in service. While in service, `irq_req` stays low even if new requests arrive. A `reti` pulse ends the in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext0_n | input | 1 | External request 0, active low |
| ext1_n | input | 1 | External request 1, active low |
| ext0_edge | input | 1 | 1: external 0 uses falling-edge mode, 0: level mode |
| ext1_edge | input | 1 | 1: external 1 uses falling-edge mode, 0: level mode |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| t2_ovf | input | 1 | Timer 2 overflow flag (level) |
| t2_ext | input | 1 | Timer 2 external flag (level) |
| ser_req | input | 1 | Serial port request (level) |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Write data for the enable register |
| en_rdata | output | 8 | Enable register contents |
| irq_ack | input | 1 | Processor takes the presented vector |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | A request is presented |
| irq_idx | output | 3 | Index of the presented source |
| irq_vec | output | 8 | Vector address of the presented source |
| src_pend | output | 6 | Raw pending state of each source, before masking |

## Verification
The hardest case to reach is a new edge request that arrives while an earlier request is still in service. To reach it, the bench acknowledges a timer 1 request and then pulses external 0, which has a higher priority. It then shows that the latch is held in `src_pend` while `irq_req` stays low, and that the request appears only after `reti`. The priority walk creates all six sources at the same time. It then removes enable bits from the low end one by one, so that each index and vector is presented in turn. For the timer-2 source, the bench acknowledges and returns, then confirms that the request is still asserted and that either of its two flags keeps it alive.

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int NSRC = 6,
  parameter logic [7:0] VEC_BASE = 8'h03,
  parameter int VEC_STEP = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext0_n,
  input  logic       ext1_n,
  input  logic       ext0_edge,
  input  logic       ext1_edge,
  input  logic       tmr0_ovf,
  input  logic       tmr1_ovf,
  input  logic       t2_ovf,
  input  logic       t2_ext,
  input  logic       ser_req,
  input  logic       en_wr,
  input  logic [7:0] en_wdata,
  output logic [7:0] en_rdata,
  input  logic       irq_ack,
  input  logic       reti,
  output logic       irq_req,
  output logic [2:0] irq_idx,
  output logic [7:0] irq_vec,
  output logic [5:0] src_pend
);
  localparam logic [7:0] EN_MASK = 8'hBF;

  logic [7:0] en_q;
  logic       ext0_prev, ext1_prev;
  logic       ext0_lat, ext1_lat;
  logic       tf0_q, tf1_q;
  logic       in_svc;
  logic [NSRC-1:0] act;
  logic       take;

  wire ext0_fall = ext0_prev & ~ext0_n;
  wire ext1_fall = ext1_prev & ~ext1_n;

  assign src_pend = {t2_ovf | t2_ext, ser_req, tf1_q,
                     ext1_edge ? ext1_lat : ~ext1_n,
                     tf0_q,
                     ext0_edge ? ext0_lat : ~ext0_n};

  assign act      = src_pend & en_q[NSRC-1:0] & {NSRC{en_q[7]}};
  assign irq_req  = (|act) & ~in_svc;
  assign take     = irq_ack & irq_req;
  assign en_rdata = en_q;

  always_comb begin
    irq_idx = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (act[i]) irq_idx = 3'(i);
  end

  assign irq_vec = VEC_BASE + 8'(VEC_STEP) * {5'd0, irq_idx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      ext0_prev <= 1'b1;
      ext1_prev <= 1'b1;
      ext0_lat  <= 1'b0;
      ext1_lat  <= 1'b0;
      tf0_q     <= 1'b0;
      tf1_q     <= 1'b0;
      in_svc    <= 1'b0;
    end else begin
      ext0_prev <= ext0_n;
      ext1_prev <= ext1_n;

      if (en_wr) en_q <= en_wdata & EN_MASK;

      if (ext0_edge && ext0_fall)             ext0_lat <= 1'b1;
      else if (!ext0_edge)                    ext0_lat <= 1'b0;
      else if (take && irq_idx == 3'd0)       ext0_lat <= 1'b0;

      if (ext1_edge && ext1_fall)             ext1_lat <= 1'b1;
      else if (!ext1_edge)                    ext1_lat <= 1'b0;
      else if (take && irq_idx == 3'd2)       ext1_lat <= 1'b0;

      if (tmr0_ovf)                           tf0_q <= 1'b1;
      else if (take && irq_idx == 3'd1)       tf0_q <= 1'b0;

      if (tmr1_ovf)                           tf1_q <= 1'b1;
      else if (take && irq_idx == 3'd3)       tf1_q <= 1'b0;

      if (take)      in_svc <= 1'b1;
      else if (reti) in_svc <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_req,
  input logic [2:0] irq_idx,
  input logic [7:0] irq_vec,
  input logic       irq_ack,
  input logic [7:0] en_rdata,
  input logic [5:0] src_pend
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rdata[6] == 1'b0);

  // R3
  global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rdata[7] |-> !irq_req);

  // R5
  top_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && src_pend[0] && en_rdata[0]) |-> irq_idx == 3'd0);

  // R6
  vector_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_vec == {2'b00, irq_idx, 3'b011});

  // R10
  hold_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !irq_req);
endmodule

bind irq_ctl irq_ctl_chk chk_i (.*);

// File: tb/irq_ctl_tb_top.sv
module irq_ctl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext0_n = 1, ext1_n = 1, ext0_edge = 1, ext1_edge = 1;
  logic tmr0_ovf = 0, tmr1_ovf = 0, t2_ovf = 0, t2_ext = 0, ser_req = 0;
  logic en_wr = 0, irq_ack = 0, reti = 0;
  logic [7:0] en_wdata = '0;
  logic [7:0] en_rdata, irq_vec;
  logic [2:0] irq_idx;
  logic [5:0] src_pend;
  logic irq_req;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctl dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #(CLK_PERIOD/4);
  endtask

  task automatic do_reset();
    ext0_n = 1; ext1_n = 1; ext0_edge = 1; ext1_edge = 1;
    tmr0_ovf = 0; tmr1_ovf = 0; t2_ovf = 0; t2_ext = 0; ser_req = 0;
    en_wr = 0; irq_ack = 0; reti = 0;
    rst_n = 0; tick(); tick(); rst_n = 1; tick();
  endtask

  task automatic wr_en(input logic [7:0] v);
    en_wr = 1; en_wdata = v; tick(); en_wr = 0; #1;
  endtask

  task automatic ack();  irq_ack = 1; tick(); irq_ack = 0; #1; endtask
  task automatic ret();  reti = 1; tick(); reti = 0; #1; endtask

  task automatic t_reset();
    do_reset();
    chk("R1 en", en_rdata, 0);
    chk("R1 req", irq_req, 0);
    chk("R1 pend", src_pend, 0);
  endtask

  task automatic t_enreg();
    do_reset();
    wr_en(8'hFF);
    chk("R2 reserved bit", en_rdata, 8'hBF);
    wr_en(8'h41);
    chk("R2 write", en_rdata, 8'h01);
  endtask

  task automatic t_global();
    do_reset();
    tmr0_ovf = 1; tick(); tmr0_ovf = 0; #1;
    wr_en(8'h3F);
    chk("R3 masked", irq_req, 0);
    wr_en(8'h82);
    chk("R3 unmasked", irq_req, 1);
    chk("R8 idx", irq_idx, 1);
    chk("R6 vec t0", irq_vec, 8'h0B);
    ack();
    chk("R8 flag cleared", src_pend[1], 0);
    ret();
    chk("R8 no req", irq_req, 0);
  endtask

  task automatic t_perenable();
    do_reset();
    ser_req = 1;
    wr_en(8'hAF);
    chk("R4 ser masked", irq_req, 0);
    wr_en(8'h90);
    chk("R4 ser on", irq_idx, 4);
    chk("R6 vec ser", irq_vec, 8'h23);
    ack();
    chk("R9 ser kept", src_pend[4], 1);
    ret();
    chk("R9 ser re-req", irq_req, 1);
  endtask

  task automatic t_priority();
    do_reset();
    ext0_edge = 0; ext1_edge = 0; ext0_n = 0; ext1_n = 0;
    ser_req = 1; t2_ovf = 1;
    tmr0_ovf = 1; tmr1_ovf = 1; tick(); tmr0_ovf = 0; tmr1_ovf = 0; #1;
    chk("R5 all pend", src_pend, 6'h3F);
    for (int k = 0; k < 6; k++) begin
      wr_en(8'h80 | ((8'h3F << k) & 8'h3F));
      chk("R5 idx", irq_idx, k);
      chk("R6 vec", irq_vec, 3 + 8*k);
    end
  endtask

  task automatic t_edge();
    do_reset();
    wr_en(8'h81);
    ext0_n = 0; tick(); ext0_n = 1; #1;
    chk("R7 latched", src_pend[0], 1);
    chk("R7 req", irq_req, 1);
    ack();
    chk("R7 latch cleared", src_pend[0], 0);
    ret();
    chk("R7 no req", irq_req, 0);
    ext0_edge = 0; ext0_n = 0; #1;
    chk("R7 level req", irq_req, 1);
    ack(); ret();
    chk("R7 level held", irq_req, 1);
    ext0_n = 1; #1;
    chk("R7 level gone", irq_req, 0);
  endtask

  task automatic t_t2();
    do_reset();
    t2_ovf = 1;
    wr_en(8'hA0);
    chk("R9 t2 idx", irq_idx, 5);
    chk("R6 vec t2", irq_vec, 8'h2B);
    ack();
    chk("R10 in service", irq_req, 0);
    chk("R9 t2 kept", src_pend[5], 1);
    ret();
    chk("R9 t2 re-req", irq_req, 1);
    t2_ovf = 0; t2_ext = 1; #1;
    chk("R9 ext flag", src_pend[5], 1);
    t2_ext = 0; #1;
    chk("R9 none", src_pend[5], 0);
  endtask

  task automatic t_service();
    do_reset();
    tmr1_ovf = 1; tick(); tmr1_ovf = 0; #1;
    wr_en(8'h89);
    chk("R10 t1 idx", irq_idx, 3);
    ack();
    ext0_n = 0; tick(); ext0_n = 1; #1;
    chk("R10 ext0 latched", src_pend[0], 1);
    chk("R10 held off", irq_req, 0);
    tick();
    chk("R10 still held", irq_req, 0);
    ret();
    chk("R10 after reti", irq_req, 1);
    chk("R10 ext0 idx", irq_idx, 0);
  endtask

  initial begin
    t_reset();
    t_enreg();
    t_global();
    t_perenable();
    t_priority();
    t_edge();
    t_t2();
    t_service();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule